// File: doc/BRIEF.md
# Coalescing Miss Store Buffer

This block holds retired stores whose target cache block is not yet writable in the L1 data cache of a weakly ordered core. It keeps one entry for each block that has a miss outstanding, not one entry for each store. A second store to a block that already has an entry merges into that entry byte by byte. A store that hits in L1 with write permission never enters the buffer. Entries are not kept in order. When the memory side reports that a block's fill has arrived, the buffer presents that entry's merged bytes on a drain port so they can be written into the L1 line, and then frees the entry.

Each entry also carries two speculation flags, one for speculative reads and one for speculative writes. They travel with the data through the drain port so the cache line inherits them. A rollback request discards, in a single cycle, every entry that holds speculatively written data. A fence that must not speculate is held by a stall output until the buffer has no valid entry.

Top module: `coalescing_store_buffer`

## Requirements
- R1: A valid store with `st_l1_hit` high is accepted (`st_ready` high) and allocates no entry, so `sb_empty` is unchanged in the next cycle.
- R2: An accepted miss store to a block with no entry allocates a free entry, and `sb_empty` is low from the next cycle.
- R3: At most one entry exists per block address. A miss store to a block that already has an entry is accepted even when the buffer is full. It sets the entry's byte-enable bits, and each enabled byte replaces the older byte in the same position.
- R4: The buffer has 8 entries. `sb_full` is high exactly when all 8 are valid. While full, a miss store to a block without an entry sees `st_ready` low and is not taken.
- R5: An entry's speculative read and write flags are the OR of the `st_spec_rd` and `st_spec_wr` values of every store it has taken.
- R6: When `fill_valid` names a block that has an entry, `drain_valid` is high in the same cycle. The drain port then shows that block's address, the byte-enable mask (bit b covers data bits 8b+7..8b), the data with zeros in bytes that were never written, and both speculation flags. The entry is free from the next cycle.
- R7: A fill for a block with no entry leaves `drain_valid` low and changes no entry.
- R8: `fence_stall` is high exactly when `fence_req` is high and the buffer holds at least one valid entry.
- R9: `rollback` invalidates every entry whose speculative write flag is set, and no others, by the next cycle. No miss store is accepted in a rollback cycle. A fill that matches an entry being discarded does not drain it.
- R10: After reset the buffer is empty: `sb_empty` high, `sb_full` low, `drain_valid` low.
- R11: A miss store whose block equals the fill block in the same cycle is not accepted (`st_ready` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Retired store presented |
| st_ready | output | 1 | Store taken this cycle |
| st_blk_addr | input | BLK_ADDR_W | Block address of the store |
| st_byte_en | input | BLOCK_BYTES | Bytes written within the block |
| st_wdata | input | 8*BLOCK_BYTES | Store data aligned to the block |
| st_l1_hit | input | 1 | Block is writable in L1; store bypasses the buffer |
| st_spec_rd | input | 1 | Speculative read flag to merge into the entry |
| st_spec_wr | input | 1 | Speculative write flag to merge into the entry |
| fill_valid | input | 1 | A block fill has returned |
| fill_blk_addr | input | BLK_ADDR_W | Block address of the fill |
| rollback | input | 1 | Discard all speculatively written entries |
| fence_req | input | 1 | A non-speculative fence is waiting |
| fence_stall | output | 1 | Fence must wait for the buffer to empty |
| drain_valid | output | 1 | Merged entry is presented for L1 write |
| drain_blk_addr | output | BLK_ADDR_W | Block address being drained |
| drain_byte_en | output | BLOCK_BYTES | Valid bytes of the drained block |
| drain_data | output | 8*BLOCK_BYTES | Merged bytes of the drained block |
| drain_spec_rd | output | 1 | Speculative read flag for the L1 line |
| drain_spec_wr | output | 1 | Speculative write flag for the L1 line |
| sb_empty | output | 1 | No valid entry |
| sb_full | output | 1 | All entries valid |

## Verification
The assertions assume that the fill side reports only blocks the core actually requested. They also assume that a store and a fill for the same block never both take effect in one cycle, which the block enforces itself through R11. The checks on entry lifetime expect `rollback` to be a single-cycle pulse that is observed before a new store is taken. The stimulus uses a small set of block addresses so that a reference model in the bench can track every block's mask, bytes and flags. It drives inputs only at the falling edge, never gives a store and a rollback to the same block the chance to race, and covers full, merging, conflicting and rollback cycles on purpose.

// File: rtl/sb_pkg.sv
// Shared types for the coalescing store buffer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sb_pkg;
    // What the buffer does with the store presented in the current cycle
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BYPASS = 3'd1,
        ST_MERGE  = 3'd2,
        ST_ALLOC  = 3'd3,
        ST_STALL  = 3'd4
    } st_action_e;
endpackage

// File: rtl/sb_match.sv
// Block-address comparator array: flags every valid entry whose tag equals key.
// Assumes: the caller keeps tags unique, so the result is at most one-hot.
module sb_match #(
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 26
) (
    input  logic [N_ENT-1:0]  valid_vec,
    input  logic [ADDR_W-1:0] tag_vec [N_ENT],
    input  logic [ADDR_W-1:0] key,
    output logic [N_ENT-1:0]  hit_vec
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        // compare one entry's tag with the key
        assign hit_vec[i] = valid_vec[i] && (tag_vec[i] == key);
    end
endmodule

// File: rtl/sb_free_pick.sv
// Selects the lowest-numbered invalid entry as the allocation target.
// Assumes: a one-hot result, or all zeros when every entry is valid.
module sb_free_pick #(
    parameter int N_ENT = 8
) (
    input  logic [N_ENT-1:0] valid_vec,
    output logic [N_ENT-1:0] pick_vec,
    output logic             any_free
);
    // ripple a "taken" token from entry 0 upward
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            pick_vec[i] = !valid_vec[i] && !taken;
            taken       = taken || !valid_vec[i];
        end
    end

    assign any_free = ~&valid_vec;
endmodule

// File: rtl/sb_entry.sv
// One buffer entry: block tag, byte mask, block bytes and two speculation flags.
// Assumes: alloc_i and merge_i are never both high; free_i and kill_i win over
// either, and the top never combines them for this entry in one cycle.
module sb_entry #(
    parameter int ADDR_W      = 26,
    parameter int BLOCK_BYTES = 8,
    localparam int DATA_W     = 8 * BLOCK_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_i,
    input  logic                   merge_i,
    input  logic                   free_i,
    input  logic                   kill_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [BLOCK_BYTES-1:0] be_i,
    input  logic [DATA_W-1:0]      data_i,
    input  logic                   rd_i,
    input  logic                   wr_i,
    output logic                   valid_o,
    output logic [ADDR_W-1:0]      addr_o,
    output logic [BLOCK_BYTES-1:0] be_o,
    output logic [DATA_W-1:0]      data_o,
    output logic                   rd_o,
    output logic                   wr_o
);
    logic                   valid_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [BLOCK_BYTES-1:0] be_q;
    logic [DATA_W-1:0]      data_q;
    logic                   rd_q;
    logic                   wr_q;
    logic [DATA_W-1:0]      data_nxt;
    logic                   drop;

    // entry disappears on its fill, or on rollback if it holds speculative writes
    assign drop = free_i || (kill_i && wr_q);

    // per-byte merge: enabled bytes take new data, fresh entries start from zero
    always_comb begin
        for (int b = 0; b < BLOCK_BYTES; b++) begin
            if (be_i[b])
                data_nxt[b*8 +: 8] = data_i[b*8 +: 8];
            else if (alloc_i)
                data_nxt[b*8 +: 8] = 8'h00;
            else
                data_nxt[b*8 +: 8] = data_q[b*8 +: 8];
        end
    end

    // state update for valid, tag, mask, data and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            data_q  <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else if (drop) begin
            valid_q <= 1'b0;
            be_q    <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else if (alloc_i) begin
            valid_q <= 1'b1;
            addr_q  <= addr_i;
            be_q    <= be_i;
            data_q  <= data_nxt;
            rd_q    <= rd_i;
            wr_q    <= wr_i;
        end else if (merge_i) begin
            be_q    <= be_q | be_i;
            data_q  <= data_nxt;
            rd_q    <= rd_q | rd_i;
            wr_q    <= wr_q | wr_i;
        end
    end

    assign valid_o = valid_q;
    assign addr_o  = addr_q;
    assign be_o    = be_q;
    assign data_o  = data_q;
    assign rd_o    = rd_q;
    assign wr_o    = wr_q;

    // R9
    rollback_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_i && valid_q && wr_q) |=> !valid_q);

    // R6
    fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_i && valid_q) |=> !valid_q);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && merge_i && !drop) |=> (rd_q >= $past(rd_q)) && (wr_q >= $past(wr_q)));
endmodule

// File: rtl/coalescing_store_buffer.sv
// Unordered, block-coalescing buffer for stores that miss in L1.
// Holds one entry per outstanding block, merges later stores into it, drains
// an entry with its speculation flags when the block's fill returns, and
// discards speculatively written entries on rollback.
// Assumes: fills name blocks previously requested; rollback is a one-cycle pulse.
module coalescing_store_buffer #(
    parameter int N_ENT       = 8,
    parameter int BLK_ADDR_W  = 26,
    parameter int BLOCK_BYTES = 8,
    localparam int DATA_W     = 8 * BLOCK_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    output logic                   st_ready,
    input  logic [BLK_ADDR_W-1:0]  st_blk_addr,
    input  logic [BLOCK_BYTES-1:0] st_byte_en,
    input  logic [DATA_W-1:0]      st_wdata,
    input  logic                   st_l1_hit,
    input  logic                   st_spec_rd,
    input  logic                   st_spec_wr,
    input  logic                   fill_valid,
    input  logic [BLK_ADDR_W-1:0]  fill_blk_addr,
    input  logic                   rollback,
    input  logic                   fence_req,
    output logic                   fence_stall,
    output logic                   drain_valid,
    output logic [BLK_ADDR_W-1:0]  drain_blk_addr,
    output logic [BLOCK_BYTES-1:0] drain_byte_en,
    output logic [DATA_W-1:0]      drain_data,
    output logic                   drain_spec_rd,
    output logic                   drain_spec_wr,
    output logic                   sb_empty,
    output logic                   sb_full
);
    import sb_pkg::*;

    logic [N_ENT-1:0]       ent_valid;
    logic [BLK_ADDR_W-1:0]  ent_addr [N_ENT];
    logic [BLOCK_BYTES-1:0] ent_be   [N_ENT];
    logic [DATA_W-1:0]      ent_data [N_ENT];
    logic [N_ENT-1:0]       ent_rd;
    logic [N_ENT-1:0]       ent_wr;

    logic [N_ENT-1:0] st_hit_vec;
    logic [N_ENT-1:0] fill_hit_vec;
    logic [N_ENT-1:0] free_pick;
    logic             any_free;
    logic             st_matched;
    logic             fill_conflict;
    logic [N_ENT-1:0] drain_en;
    st_action_e       action;

    // tag lookup for the incoming store
    sb_match #(.N_ENT(N_ENT), .ADDR_W(BLK_ADDR_W)) u_st_match (
        .valid_vec (ent_valid),
        .tag_vec   (ent_addr),
        .key       (st_blk_addr),
        .hit_vec   (st_hit_vec)
    );

    // tag lookup for the returning fill
    sb_match #(.N_ENT(N_ENT), .ADDR_W(BLK_ADDR_W)) u_fill_match (
        .valid_vec (ent_valid),
        .tag_vec   (ent_addr),
        .key       (fill_blk_addr),
        .hit_vec   (fill_hit_vec)
    );

    // allocation target
    sb_free_pick #(.N_ENT(N_ENT)) u_pick (
        .valid_vec (ent_valid),
        .pick_vec  (free_pick),
        .any_free  (any_free)
    );

    assign st_matched    = |st_hit_vec;
    assign fill_conflict = fill_valid && (fill_blk_addr == st_blk_addr);

    // classify the presented store
    always_comb begin
        if (!st_valid)
            action = ST_IDLE;
        else if (st_l1_hit)
            action = ST_BYPASS;
        else if (rollback || fill_conflict)
            action = ST_STALL;
        else if (st_matched)
            action = ST_MERGE;
        else if (any_free)
            action = ST_ALLOC;
        else
            action = ST_STALL;
    end

    assign st_ready = (action != ST_STALL);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        // a fill drains its entry unless rollback is discarding that entry
        assign drain_en[i] = fill_valid && fill_hit_vec[i] && !(rollback && ent_wr[i]);

        sb_entry #(.ADDR_W(BLK_ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc_i ((action == ST_ALLOC) && free_pick[i]),
            .merge_i ((action == ST_MERGE) && st_hit_vec[i]),
            .free_i  (drain_en[i]),
            .kill_i  (rollback),
            .addr_i  (st_blk_addr),
            .be_i    (st_byte_en),
            .data_i  (st_wdata),
            .rd_i    (st_spec_rd),
            .wr_i    (st_spec_wr),
            .valid_o (ent_valid[i]),
            .addr_o  (ent_addr[i]),
            .be_o    (ent_be[i]),
            .data_o  (ent_data[i]),
            .rd_o    (ent_rd[i]),
            .wr_o    (ent_wr[i])
        );
    end

    // one-hot OR mux of the draining entry onto the drain port
    always_comb begin
        drain_blk_addr = '0;
        drain_byte_en  = '0;
        drain_data     = '0;
        drain_spec_rd  = 1'b0;
        drain_spec_wr  = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (drain_en[i]) begin
                drain_blk_addr = drain_blk_addr | ent_addr[i];
                drain_byte_en  = drain_byte_en  | ent_be[i];
                drain_data     = drain_data     | ent_data[i];
                drain_spec_rd  = drain_spec_rd  | ent_rd[i];
                drain_spec_wr  = drain_spec_wr  | ent_wr[i];
            end
        end
    end

    assign drain_valid = |drain_en;
    assign sb_empty    = ~|ent_valid;
    assign sb_full     = &ent_valid;
    assign fence_stall = fence_req && !sb_empty;

    // R3
    single_store_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hit_vec));

    // R3
    single_fill_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_hit_vec));

    // R2
    alloc_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ST_ALLOC) |=> !sb_empty);

    // R4
    full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_full && st_valid && !st_l1_hit && !st_matched) |-> !st_ready);

    // R6
    drain_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && (action != ST_ALLOC)) |=>
            ($countones(ent_valid) < $past($countones(ent_valid))));

    // R9
    rollback_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> ((ent_valid & ent_wr) == '0));

    // R1
    bypass_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_l1_hit && !fill_valid && !rollback) |=>
            ($countones(ent_valid) == $past($countones(ent_valid))));
endmodule

// File: tb/tb_coalescing_store_buffer.sv
// Self-checking bench: reference model over 16 block addresses, swept stimulus.
module tb_coalescing_store_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 26;
    localparam int BB   = 8;
    localparam int DW   = 64;
    localparam int NENT = 8;
    localparam int NBLK = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_blk_addr = '0;
    logic [BB-1:0] st_byte_en = '0;
    logic [DW-1:0] st_wdata = '0;
    logic          st_l1_hit = 1'b0;
    logic          st_spec_rd = 1'b0;
    logic          st_spec_wr = 1'b0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_blk_addr = '0;
    logic          rollback = 1'b0;
    logic          fence_req = 1'b0;
    logic          fence_stall;
    logic          drain_valid;
    logic [AW-1:0] drain_blk_addr;
    logic [BB-1:0] drain_byte_en;
    logic [DW-1:0] drain_data;
    logic          drain_spec_rd;
    logic          drain_spec_wr;
    logic          sb_empty;
    logic          sb_full;

    coalescing_store_buffer #(.N_ENT(NENT), .BLK_ADDR_W(AW), .BLOCK_BYTES(BB)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_blk_addr(st_blk_addr),
        .st_byte_en(st_byte_en), .st_wdata(st_wdata), .st_l1_hit(st_l1_hit),
        .st_spec_rd(st_spec_rd), .st_spec_wr(st_spec_wr),
        .fill_valid(fill_valid), .fill_blk_addr(fill_blk_addr),
        .rollback(rollback), .fence_req(fence_req), .fence_stall(fence_stall),
        .drain_valid(drain_valid), .drain_blk_addr(drain_blk_addr),
        .drain_byte_en(drain_byte_en), .drain_data(drain_data),
        .drain_spec_rd(drain_spec_rd), .drain_spec_wr(drain_spec_wr),
        .sb_empty(sb_empty), .sb_full(sb_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model, indexed by block address
    bit          m_valid [NBLK];
    bit [BB-1:0] m_be    [NBLK];
    bit [DW-1:0] m_data  [NBLK];
    bit          m_rd    [NBLK];
    bit          m_wr    [NBLK];

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < NBLK; i++) c += m_valid[i] ? 1 : 0;
        return c;
    endfunction

    function automatic bit [DW-1:0] expand(input bit [BB-1:0] be);
        bit [DW-1:0] r = '0;
        for (int b = 0; b < BB; b++) if (be[b]) r[b*8 +: 8] = 8'hFF;
        return r;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check before posedge, update model after it
    task automatic step(input bit sv, input int a, input bit [BB-1:0] be, input bit [DW-1:0] d,
                        input bit hit, input bit rd, input bit wr,
                        input bit fv, input int fa, input bit rb);
        bit exp_rdy, exp_drain;
        @(negedge clk);
        st_valid = sv; st_blk_addr = AW'(a); st_byte_en = be; st_wdata = d;
        st_l1_hit = hit; st_spec_rd = rd; st_spec_wr = wr;
        fill_valid = fv; fill_blk_addr = AW'(fa); rollback = rb; fence_req = 1'b1;
        #1;
        if (!sv || hit)               exp_rdy = 1'b1;
        else if (rb)                  exp_rdy = 1'b0;
        else if (fv && fa == a)       exp_rdy = 1'b0;
        else if (m_valid[a])          exp_rdy = 1'b1;
        else                          exp_rdy = (m_count() < NENT);
        exp_drain = fv && m_valid[fa] && !(rb && m_wr[fa]);
        if (sv && !hit && fv && fa == a) chk("R11 conflict ready", st_ready, 0);
        else if (rb && sv && !hit)       chk("R9 no store on rollback", st_ready, 0);
        else if (sv && hit)              chk("R1 bypass ready", st_ready, 1);
        else                             chk("R4 st_ready", st_ready, exp_rdy);
        chk(fv && !m_valid[fa] ? "R7 drain_valid" : "R6 drain_valid", drain_valid, exp_drain);
        if (exp_drain) begin
            chk("R6 drain addr", drain_blk_addr, fa);
            chk("R3 drain mask", drain_byte_en, m_be[fa]);
            chk("R3 drain data", drain_data, m_data[fa]);
            chk("R5 drain rd", drain_spec_rd, m_rd[fa]);
            chk("R5 drain wr", drain_spec_wr, m_wr[fa]);
        end
        chk("R10 empty", sb_empty, m_count() == 0);
        chk("R4 full", sb_full, m_count() == NENT);
        chk("R8 fence_stall", fence_stall, m_count() != 0);
        @(posedge clk);
        if (exp_drain) m_valid[fa] = 1'b0;
        if (rb) for (int i = 0; i < NBLK; i++) if (m_wr[i]) m_valid[i] = 1'b0;
        for (int i = 0; i < NBLK; i++) if (!m_valid[i]) begin m_be[i] = '0; m_rd[i] = 0; m_wr[i] = 0; end
        if (sv && !hit && exp_rdy) begin
            if (!m_valid[a]) begin
                m_valid[a] = 1'b1; m_be[a] = '0; m_data[a] = '0; m_rd[a] = 0; m_wr[a] = 0;
            end
            m_be[a]   = m_be[a] | be;
            m_data[a] = (m_data[a] & ~expand(be)) | (d & expand(be));
            m_rd[a]   = m_rd[a] | rd;
            m_wr[a]   = m_wr[a] | wr;
        end
    endtask

    task automatic store(input int a, input bit [BB-1:0] be, input bit [DW-1:0] d,
                         input bit hit, input bit rd, input bit wr);
        step(1, a, be, d, hit, rd, wr, 0, 0, 0);
    endtask

    task automatic fill(input int a);
        step(0, 0, '0, '0, 0, 0, 0, 1, a, 0);
    endtask

    task automatic idle();
        step(0, 0, '0, '0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < NBLK; i++) begin
            m_valid[i] = 0; m_be[i] = '0; m_data[i] = '0; m_rd[i] = 0; m_wr[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10: reset state
        #1;
        chk("R10 reset empty", sb_empty, 1);
        chk("R10 reset full", sb_full, 0);
        chk("R10 reset drain", drain_valid, 0);
        idle();
        // R1: hit stores never allocate
        for (int a = 0; a < 4; a++) store(a, 8'hFF, 64'hA5A5_0000_0000_0000 + a, 1, 1, 1);
        idle();
        // R2/R4: fill all entries with distinct byte patterns
        for (int a = 0; a < NENT; a++)
            store(a, 8'(1 << a) | 8'h01, {8{8'(8'h10 + a)}}, 0, 0, 0);
        idle();
        // R4: new block refused while full; R3: merge still taken
        store(9, 8'hFF, 64'h1, 0, 0, 0);
        store(3, 8'hF0, 64'hDEAD_BEEF_0000_0000, 0, 1, 0);
        // R3/R5: merge sweep with overlapping bytes and varied flags
        for (int a = 0; a < NENT; a++)
            for (int k = 0; k < 3; k++)
                store(a, 8'(8'h0F << k), {4{16'(a * 256 + k)}}, 0, (a % 2) == 1, (a % 4) >= 2);
        // R11: store and fill to the same block
        step(1, 5, 8'hFF, 64'h55, 0, 0, 0, 1, 5, 0);
        idle();
        // R7: fills for unknown blocks
        fill(12);
        fill(5);
        // R9: rollback with a fill to a discarded block and a store attempt
        step(1, 13, 8'h01, 64'h7, 0, 0, 0, 1, 2, 1);
        idle();
        // R6/R7: drain everything, including already freed blocks
        for (int a = 0; a < NBLK; a++) fill(a);
        idle();
        // second round: full buffer of speculative writers, then rollback
        for (int a = 8; a < 16; a++) store(a, 8'hFF, {2{32'(a)}}, 0, 0, (a % 3) != 0);
        step(0, 0, '0, '0, 0, 0, 0, 0, 0, 1);
        idle();
        for (int a = 0; a < NBLK; a++) fill(a);
        idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule